// File: doc/BRIEF.md
# Single-Slope Converter Counter and Serial Readout

This block is the digital half of a single-slope (ramp) analog-to-digital converter. When the measure input rises, a counter starts from zero and counts one step per clock while the analog ramp climbs. The comparator output enters through a two-flop synchroniser. When it trips, the counter stops on the value it held at the clock edge that first sampled the trip, so the two cycles of synchroniser delay do not bias the result. A held-count flag leaves the block as an output, so a wider counter outside the chip can time the same conversion.

A stored offset word, supplied as a static input, is subtracted from the held count to remove the ramp's start offset. The difference clamps at zero. The corrected code appears on a parallel output and can also be read serially. Pulling chip select low loads it into a shift register, and each falling SPI clock edge moves to the next bit, most significant first. Both SPI lines are resynchronised into the system clock domain. Dropping measure returns the block to its ready state. If the ramp reaches full scale without a trip, the count stays at all ones and an overrange flag is raised.

Top module: `slope_adc_backend`

## Requirements
- R1: While `ready` is high, a high `measure` sampled at a clock edge starts a conversion. `ready` falls after that edge and the count is 0. Each later edge adds one to the count.
- R2: The held count equals the number of clock edges from the edge that started the conversion to the first edge at which `cmpTrip` is sampled high. `freezeOut` rises after the second clock edge that follows the trip-sampling edge. The held count then stays constant while `freezeOut` is high.
- R3: The counter is `CNT_W` bits wide (default 14), so a code covers 0 to 16383. All `CNT_W` bits are delivered serially.
- R4: If the count has reached all ones and no trip has been seen, the next edge stops the count at all ones and sets both `overRange` and `freezeOut`. A trip that is due on that same edge wins: the count stops on the value of R2 and `overRange` stays low.
- R5: While `freezeOut` is high, `corrCode` equals the held count minus `offsetCode`, or 0 when `offsetCode` is greater than or equal to the held count. Otherwise `corrCode` is 0.
- R6: About three clocks after a falling `csN`, the corrected code is loaded for readout. `sdo` shows the most significant bit, and each falling `sclk` edge while `csN` is low advances one bit towards the least significant. While `csN` is high, `sdo` is 0.
- R7: A low `measure` sampled while the count is held returns the block to ready after that edge. `overRange` clears and `corrCode` goes to 0.
- R8: A low `measure` sampled during counting abandons the conversion. `ready` returns after that edge and `freezeOut` does not rise.
- R9: `cmpTrip` has no effect while the block is ready: `ready` stays high and `freezeOut` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| measure | input | 1 | Conversion request level; rise starts, fall rearms |
| cmpTrip | input | 1 | Asynchronous comparator output, high once the ramp passes the input |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low serial chip select |
| offsetCode | input | CNT_W | Stored start-offset word subtracted from the count |
| sdo | output | 1 | Serial data, most significant bit first |
| freezeOut | output | 1 | High while the count is held |
| ready | output | 1 | High when a new conversion may start |
| overRange | output | 1 | Count saturated without a comparator trip |
| corrCode | output | CNT_W | Offset-corrected held count |

## Verification
A comparator trip can become due on the same clock edge at which the counter sits at all ones. Freeze and overrange then compete for one cycle. The bench provokes this by driving the trip so it is first sampled at count 16382, so its synchronised copy arrives exactly when the count is 16383. It then expects a held code of 16382 with `overRange` low. A separate run with no trip expects saturation at 16383 with `overRange` high. A second overlap is the offset clamp meeting a small held count: offsets equal to, one below and far above the count are each judged against the clamped difference.

// File: rtl/slope_adc_pkg.sv
package slope_adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } convState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clr;      // force count to zero
    logic inc;      // count one more clock
    logic backOff;  // stop and step back over the synchroniser delay
    logic load;     // capture corrected code into the shift register
    logic shift;    // advance serial output by one bit
    logic show;     // present corrected code on the parallel output
  } dpStrobe_t;

endpackage

// File: rtl/slope_adc_ctrl.sv
module slope_adc_ctrl
  import slope_adc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      measure,
  input  logic      cmpTrip,
  input  logic      sclk,
  input  logic      csN,
  input  logic      cntAtMax,
  output dpStrobe_t strb,
  output logic      ready,
  output logic      freezeOut,
  output logic      overRange,
  output logic      csActive
);

  localparam int SYNC_LEN = 2;

  convState_e state, stNext;
  logic [SYNC_LEN-1:0] tripSync, sclkSync, csSync;
  logic sclkPrev, csPrev;
  logic tripSeen, ovrSet, sclkFall, csFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tripSync <= '0;
      sclkSync <= '0;
      csSync   <= '1;
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      tripSync <= {tripSync[SYNC_LEN-2:0], cmpTrip};
      sclkSync <= {sclkSync[SYNC_LEN-2:0], sclk};
      csSync   <= {csSync[SYNC_LEN-2:0], csN};
      sclkPrev <= sclkSync[SYNC_LEN-1];
      csPrev   <= csSync[SYNC_LEN-1];
    end
  end

  assign tripSeen = tripSync[SYNC_LEN-1];
  assign csActive = !csSync[SYNC_LEN-1];
  assign csFall   = csPrev && !csSync[SYNC_LEN-1];
  assign sclkFall = sclkPrev && !sclkSync[SYNC_LEN-1];

  always_comb begin
    stNext = state;
    ovrSet = 1'b0;
    strb   = '0;
    unique case (state)
      ST_IDLE: begin
        strb.clr = 1'b1;
        if (measure) stNext = ST_COUNT;
      end
      ST_COUNT: begin
        if (!measure) begin
          stNext = ST_IDLE;
        end else if (tripSeen) begin
          strb.backOff = 1'b1;
          stNext = ST_HOLD;
        end else if (cntAtMax) begin
          ovrSet = 1'b1;
          stNext = ST_HOLD;
        end else begin
          strb.inc = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!measure) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
    strb.show  = (state == ST_HOLD);
    strb.load  = csFall;
    strb.shift = sclkFall && csActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      overRange <= 1'b0;
    end else begin
      state <= stNext;
      if (stNext == ST_IDLE) overRange <= 1'b0;
      else if (ovrSet)       overRange <= 1'b1;
    end
  end

  assign ready     = (state == ST_IDLE);
  assign freezeOut = (state == ST_HOLD);

  AST_REARM_FROM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (freezeOut && !measure) |=> (ready && !overRange)); // R7

  AST_IDLE_TRIP_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !measure) |=> (ready && !freezeOut)); // R9

  AST_ABORT_NO_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !freezeOut && !measure) |=> (ready && !freezeOut)); // R8

endmodule

// File: rtl/slope_adc_dp.sv
module slope_adc_dp
  import slope_adc_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] offsetCode,
  output logic [CNT_W-1:0] cntQ,
  output logic             cntAtMax,
  output logic [CNT_W-1:0] corrCode,
  output logic             sdoBit
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W:0]   diffExt;
  logic [CNT_W-1:0] corrVal, shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strb.clr) begin
      cntQ <= '0;
    end else if (strb.inc) begin
      cntQ <= cntQ + 1'b1;
    end else if (strb.backOff) begin
      cntQ <= (cntQ == '0) ? '0 : cntQ - 1'b1;
    end
  end

  assign cntAtMax = (cntQ == CNT_MAX);

  assign diffExt  = {1'b0, cntQ} - {1'b0, offsetCode};
  assign corrVal  = diffExt[CNT_W] ? '0 : diffExt[CNT_W-1:0];
  assign corrCode = strb.show ? corrVal : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.load) begin
      shiftReg <= corrCode;
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[CNT_W-2:0], 1'b0};
    end
  end

  assign sdoBit = shiftReg[CNT_W-1];

  AST_CORR_NOT_ABOVE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strb.show |-> (corrCode <= cntQ)); // R5

  AST_ZERO_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.show && offsetCode == '0) |-> (corrCode == cntQ)); // R5

endmodule

// File: rtl/slope_adc_backend.sv
module slope_adc_backend
  import slope_adc_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             measure,
  input  logic             cmpTrip,
  input  logic             sclk,
  input  logic             csN,
  input  logic [CNT_W-1:0] offsetCode,
  output logic             sdo,
  output logic             freezeOut,
  output logic             ready,
  output logic             overRange,
  output logic [CNT_W-1:0] corrCode
);

  dpStrobe_t        strb;
  logic             cntAtMax, csActive, sdoBit;
  logic [CNT_W-1:0] cntQ;

  slope_adc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .measure   (measure),
    .cmpTrip   (cmpTrip),
    .sclk      (sclk),
    .csN       (csN),
    .cntAtMax  (cntAtMax),
    .strb      (strb),
    .ready     (ready),
    .freezeOut (freezeOut),
    .overRange (overRange),
    .csActive  (csActive)
  );

  slope_adc_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .offsetCode (offsetCode),
    .cntQ       (cntQ),
    .cntAtMax   (cntAtMax),
    .corrCode   (corrCode),
    .sdoBit     (sdoBit)
  );

  assign sdo = csActive & sdoBit;

  AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ready && measure) |=> (!ready && cntQ == '0)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (freezeOut && $past(freezeOut)) |-> $stable(cntQ)); // R2

  AST_OVR_AT_FULL_SCALE: assert property (@(posedge clk) disable iff (!rstN)
    overRange |-> (freezeOut && cntQ == '1)); // R4

endmodule

// File: tb/slope_adc_backend_test.sv
`timescale 1ns/1ps
module slope_adc_backend_test;

  localparam int CW = 14;
  localparam int FULL = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic measure = 1'b0;
  logic cmpTrip = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic [CW-1:0] offsetCode = '0;
  logic sdo, freezeOut, ready, overRange;
  logic [CW-1:0] corrCode;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slope_adc_backend #(.CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .measure(measure), .cmpTrip(cmpTrip),
    .sclk(sclk), .csN(csN), .offsetCode(offsetCode), .sdo(sdo),
    .freezeOut(freezeOut), .ready(ready), .overRange(overRange),
    .corrCode(corrCode)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expCode(input int t, input int o);
    return (t > o) ? t - o : 0;
  endfunction

  task automatic readSerial(output int word);
    csN = 1'b0;
    repeat (6) @(negedge clk);
    word = 0;
    for (int i = 0; i < CW; i++) begin
      word = (word << 1) | int'(sdo);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rearm();
    measure = 1'b0;
    cmpTrip = 1'b0;
    @(negedge clk);
    check("R7 ready after release", int'(ready), 1);
    check("R7 code cleared", int'(corrCode), 0);
    check("R7 overrange cleared", int'(overRange), 0);
    repeat (3) @(negedge clk);
  endtask

  // trip first sampled t edges after the start edge
  task automatic convert(input int t, input int o, input bit doRead);
    int w;
    offsetCode = CW'(o);
    measure = 1'b1;
    for (int k = 0; k < t; k++) begin
      @(negedge clk);
      if (k == 0) check("R1 ready drops at start", int'(ready), 0);
    end
    cmpTrip = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2 freeze not yet", int'(freezeOut), 0);
    @(negedge clk);
    check("R2 freeze timing", int'(freezeOut), 1);
    check("R5 corrected code", int'(corrCode), expCode(t, o));
    if (doRead) begin
      readSerial(w);
      check("R6 serial word", w, expCode(t, o));
      check("R6 sdo idle with csN high", int'(sdo), 0);
      check("R2 held code stable", int'(corrCode), expCode(t, o));
    end
    rearm();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int w;
    void'($urandom(32'd7305));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("reset ready", int'(ready), 1);
    check("reset freeze", int'(freezeOut), 0);
    check("reset overrange", int'(overRange), 0);
    check("reset sdo", int'(sdo), 0);
    check("reset code", int'(corrCode), 0);

    // R9: trip while ready is ignored
    cmpTrip = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R9 ready held", int'(ready), 1);
      check("R9 no freeze", int'(freezeOut), 0);
    end
    cmpTrip = 1'b0;
    repeat (4) @(negedge clk);

    // R1: smallest count, zero offset
    convert(1, 0, 1'b1);
    // R5 clamp corners
    convert(100, 100, 1'b1);
    convert(100, 99, 1'b1);
    convert(100, 300, 1'b0);
    convert(2, 0, 1'b0);

    // constrained random conversions
    for (int n = 0; n < 12; n++) begin
      convert(int'($urandom_range(2000, 1)), int'($urandom_range(400, 0)), 1'b1);
    end

    // R8: abort during counting
    measure = 1'b1;
    repeat (50) @(negedge clk);
    measure = 1'b0;
    @(negedge clk);
    check("R8 ready after abort", int'(ready), 1);
    check("R8 no freeze after abort", int'(freezeOut), 0);
    repeat (20) @(negedge clk);
    check("R8 still no freeze", int'(freezeOut), 0);

    // R4: trip due on the full-scale edge wins over overrange
    convert(FULL - 1, 0, 1'b0);

    // R4: saturation without trip
    offsetCode = '0;
    measure = 1'b1;
    repeat (FULL + 1) @(negedge clk);
    check("R4 still counting at full scale", int'(freezeOut), 0);
    check("R4 no overrange yet", int'(overRange), 0);
    @(negedge clk);
    check("R4 freeze on saturation", int'(freezeOut), 1);
    check("R4 overrange raised", int'(overRange), 1);
    check("R4 saturated code", int'(corrCode), FULL);
    readSerial(w);
    check("R3 full-width serial word", w, FULL);
    rearm();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule